// File: doc/BRIEF.md
# Reference-Clock Oscillator Trim Calibrator

This block steers a trimmable local oscillator toward a target frequency. It compares the local clock with a slower, accurate reference clock. A counter in the reference domain marks off measurement windows of a programmable number of reference cycles. Each window end is handed to the local domain through a toggle handshake. There the number of local cycles since the previous window end is taken as the measured count, and the local counter restarts from zero.

Each measured count is checked against a programmed expected count with a symmetric tolerance band. A count above the band means the local clock is fast, so the trim word drops by one. A count below the band means it is slow, so the trim word rises by one. A count inside the band leaves the trim alone. A run of consecutive in-band windows raises a lock flag.

The trim is a saturating two's-complement word that drives the oscillator's analog tuning. `exp_cnt`, `tol` and `win_len` are meant to be static while `en` is high. `win_len` must be at least 1, and the reference clock must be slower than the local clock.

Top module: `osc_trim_cal`

## Requirements
- R1: While reset is applied and right after it, `trim` is 0, `locked` is 0 and `meas_cnt` is 0.
- R2: A window ends every `win_len` reference cycles. Each window end is seen exactly once in the local domain. At each one, `meas_cnt` becomes the number of local cycles since the previous window end.
- R3: The first window end after `en` rises only restarts the measurement and leaves `trim` unchanged.
- R4: When the measured count is greater than `exp_cnt + tol`, `trim` drops by exactly one for that window.
- R5: When the measured count plus `tol` is less than `exp_cnt`, `trim` rises by exactly one for that window. `trim` never moves by more than one in a local cycle.
- R6: `trim` is a TRIM_W-bit two's-complement value (default 6 bits). It saturates at +31 and at -32 and never wraps.
- R7: A measured count inside the band leaves `trim` unchanged. `locked` goes high once LOCK_N consecutive windows are in band (default 4). Any out-of-band window clears `locked` and restarts the run.
- R8: While `en` is low, both counters are held at zero and `locked` is 0, while `trim` keeps its value.
- R9: The local counter saturates at all-ones (2^CNT_W-1). An over-long window then reports all-ones and is treated as fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_loc | input | 1 | Local clock being trimmed |
| clk_ref | input | 1 | Accurate, slower reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| en | input | 1 | Calibration enable (local domain) |
| exp_cnt | input | CNT_W | Expected local cycles per window |
| tol | input | CNT_W | Half-width of the band accepted as on target |
| win_len | input | WIN_W | Window length in reference cycles |
| trim | output | TRIM_W | Signed trim word |
| locked | output | 1 | LOCK_N consecutive in-band windows seen |
| meas_cnt | output | CNT_W | Most recent measured local count |

## Verification
A lost or doubled window handoff shows at once in `meas_cnt`: it reads about twice the true period, or a small value, at the very next window end. A wrong band decision or a bad saturation shows as a `trim` step in the wrong direction, or as a wrap, within one window of the fault. These are checked at every local cycle. A stuck in-band counter shows as `locked` missing or early after LOCK_N windows. A stale first window shows as a `trim` step before the second window end.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    CMP_SLOW = 2'd0,
    CMP_BAND = 2'd1,
    CMP_FAST = 2'd2
  } cmp_e;

  // Band decision on zero-extended operands; hi/lo bound check without underflow.
  function automatic cmp_e classify(input logic [32:0] m, input logic [32:0] e,
                                    input logic [32:0] t);
    if (m > e + t)      return CMP_FAST;
    else if (m + t < e) return CMP_SLOW;
    else                return CMP_BAND;
  endfunction

endpackage

// File: rtl/otc_rst_sync.sv
module otc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/otc_ref_window.sv
module otc_ref_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk_ref,
  input  logic             rst_ref_n,
  input  logic             en_async,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_tog
);
  logic [1:0]       en_sync_q;
  logic             run;
  logic [WIN_W-1:0] rc_q, rc_d;
  logic             tog_q, tog_d;
  logic [WIN_W-1:0] term;

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) en_sync_q <= 2'b00;
    else            en_sync_q <= {en_sync_q[0], en_async};
  end

  assign run  = en_sync_q[1];
  assign term = win_len - WIN_W'(1);

  always_comb begin
    rc_d  = rc_q;
    tog_d = tog_q;
    if (!run) begin
      rc_d = '0;
    end else if (rc_q == term) begin
      rc_d  = '0;
      tog_d = ~tog_q;
    end else begin
      rc_d = rc_q + WIN_W'(1);
    end
  end

  always_ff @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      rc_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      rc_q  <= rc_d;
      tog_q <= tog_d;
    end
  end

  assign win_tog = tog_q;

  AST_REF_IDLE_CLEAR: assert property (@(posedge clk_ref) disable iff (!rst_ref_n)
    !run |=> rc_q == '0); // R8
endmodule

// File: rtl/otc_evt_sync.sv
module otc_evt_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_loc,
  input  logic rst_loc_n,
  input  logic tog_async,
  output logic evt_pulse
);
  localparam int SW = SYNC_N + 1;
  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_loc or negedge rst_loc_n) begin
    if (!rst_loc_n) sh_q <= '0;
    else            sh_q <= {sh_q[SW-2:0], tog_async};
  end

  assign evt_pulse = sh_q[SW-1] ^ sh_q[SW-2];

  AST_PULSE_SINGLE: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    evt_pulse |=> !evt_pulse); // R2
endmodule

// File: rtl/otc_loc_counter.sv
module otc_loc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_loc,
  input  logic             rst_loc_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_plus
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_plus = (cnt_q == CMAX) ? CMAX : cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = clr ? '0 : cnt_plus;
  end

  always_ff @(posedge clk_loc or negedge rst_loc_n) begin
    if (!rst_loc_n) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  AST_CNT_SAT: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    (cnt_q == CMAX && !clr) |=> cnt_q == CMAX); // R9
  AST_CNT_CLEAR: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    clr |=> cnt_q == '0); // R8
endmodule

// File: rtl/otc_trim_ctrl.sv
module otc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TRIM_W = 6,
  parameter int LOCK_N = 4
) (
  input  logic                     clk_loc,
  input  logic                     rst_loc_n,
  input  logic                     en,
  input  logic                     evt,
  input  logic [CNT_W-1:0]         meas_new,
  input  logic [CNT_W-1:0]         exp_cnt,
  input  logic [CNT_W-1:0]         tol,
  output logic signed [TRIM_W-1:0] trim,
  output logic                     locked,
  output logic [CNT_W-1:0]         meas_cnt
);
  localparam int BW = $clog2(LOCK_N + 1);
  localparam logic signed [TRIM_W-1:0] TMAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] TMIN = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [BW-1:0] BAND_TOP = BW'(LOCK_N);

  logic signed [TRIM_W-1:0] trim_q, trim_d;
  logic                     primed_q, primed_d;
  logic [BW-1:0]            band_q, band_d;
  logic                     lock_q, lock_d;
  logic [CNT_W-1:0]         meas_q, meas_d;
  cmp_e                     cls;

  assign cls = classify(33'(meas_new), 33'(exp_cnt), 33'(tol));

  always_comb begin
    trim_d   = trim_q;
    primed_d = primed_q;
    band_d   = band_q;
    lock_d   = lock_q;
    meas_d   = meas_q;
    if (!en) begin
      primed_d = 1'b0;
      band_d   = '0;
      lock_d   = 1'b0;
    end else if (evt) begin
      meas_d = meas_new;
      if (!primed_q) begin
        primed_d = 1'b1;
      end else begin
        case (cls)
          CMP_FAST: begin
            trim_d = (trim_q == TMIN) ? trim_q : TRIM_W'(trim_q - 1);
            band_d = '0;
            lock_d = 1'b0;
          end
          CMP_SLOW: begin
            trim_d = (trim_q == TMAX) ? trim_q : TRIM_W'(trim_q + 1);
            band_d = '0;
            lock_d = 1'b0;
          end
          default: begin
            band_d = (band_q == BAND_TOP) ? band_q : band_q + BW'(1);
            lock_d = (band_d == BAND_TOP);
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_loc or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      trim_q   <= '0;
      primed_q <= 1'b0;
      band_q   <= '0;
      lock_q   <= 1'b0;
      meas_q   <= '0;
    end else begin
      trim_q   <= trim_d;
      primed_q <= primed_d;
      band_q   <= band_d;
      lock_q   <= lock_d;
      meas_q   <= meas_d;
    end
  end

  assign trim     = trim_q;
  assign locked   = lock_q;
  assign meas_cnt = meas_q;

  AST_TRIM_STEP: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    !$stable(trim_q) |-> (trim_q == TRIM_W'($past(trim_q) + 1) ||
                          trim_q == TRIM_W'($past(trim_q) - 1))); // R5
  AST_TRIM_NOWRAP: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    trim_q == TMAX |=> trim_q != TMIN); // R6
  AST_TRIM_NOWRAP_LO: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    trim_q == TMIN |=> trim_q != TMAX); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    !$stable(trim_q) |-> !lock_q); // R7
  AST_FIRST_SKIP: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    (en && evt && !primed_q) |=> $stable(trim_q)); // R3
  AST_DIS_UNLOCK: assert property (@(posedge clk_loc) disable iff (!rst_loc_n)
    !en |=> (!lock_q && $stable(trim_q))); // R8
endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal #(
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16,
  parameter int TRIM_W = 6,
  parameter int LOCK_N = 4,
  parameter int SYNC_N = 2
) (
  input  logic                     clk_loc,
  input  logic                     clk_ref,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [CNT_W-1:0]         exp_cnt,
  input  logic [CNT_W-1:0]         tol,
  input  logic [WIN_W-1:0]         win_len,
  output logic signed [TRIM_W-1:0] trim,
  output logic                     locked,
  output logic [CNT_W-1:0]         meas_cnt
);
  logic             rst_loc_n, rst_ref_n;
  logic             win_tog, evt_pulse, cnt_clr;
  logic [CNT_W-1:0] cnt_plus;

  otc_rst_sync u_rs_loc (.clk(clk_loc), .rst_n(rst_n), .rst_sync_n(rst_loc_n));
  otc_rst_sync u_rs_ref (.clk(clk_ref), .rst_n(rst_n), .rst_sync_n(rst_ref_n));

  otc_ref_window #(.WIN_W(WIN_W)) u_win (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n), .en_async(en),
    .win_len(win_len), .win_tog(win_tog)
  );

  otc_evt_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_loc(clk_loc), .rst_loc_n(rst_loc_n), .tog_async(win_tog),
    .evt_pulse(evt_pulse)
  );

  assign cnt_clr = evt_pulse | ~en;

  otc_loc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_loc(clk_loc), .rst_loc_n(rst_loc_n), .clr(cnt_clr), .cnt_plus(cnt_plus)
  );

  otc_trim_ctrl #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .LOCK_N(LOCK_N)) u_ctrl (
    .clk_loc(clk_loc), .rst_loc_n(rst_loc_n), .en(en), .evt(evt_pulse),
    .meas_new(cnt_plus), .exp_cnt(exp_cnt), .tol(tol),
    .trim(trim), .locked(locked), .meas_cnt(meas_cnt)
  );
endmodule

// File: tb/osc_trim_cal_tb_top.sv
module osc_trim_cal_tb_top;
  localparam int LOC_PERIOD = 10;
  localparam int RATIO      = 4;
  localparam int CNT_W      = 10;
  localparam int WIN_W      = 10;
  localparam int TRIM_W     = 6;
  localparam int LOCK_N     = 4;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic clk_loc, clk_ref, rst_n, en;
  logic [CNT_W-1:0] exp_cnt, tol, meas_cnt;
  logic [WIN_W-1:0] win_len;
  logic signed [TRIM_W-1:0] trim;
  logic locked;

  int checks, errors;
  bit done;
  bit mon_on;
  int mon_dir;
  int prev_trim;

  osc_trim_cal #(.CNT_W(CNT_W), .WIN_W(WIN_W), .TRIM_W(TRIM_W), .LOCK_N(LOCK_N)) dut_i (
    .clk_loc(clk_loc), .clk_ref(clk_ref), .rst_n(rst_n), .en(en),
    .exp_cnt(exp_cnt), .tol(tol), .win_len(win_len),
    .trim(trim), .locked(locked), .meas_cnt(meas_cnt)
  );

  initial begin
    clk_loc = 1'b0;
    forever #(LOC_PERIOD / 2) clk_loc = ~clk_loc;
  end

  initial begin
    clk_ref = 1'b0;
    #2;
    forever #(LOC_PERIOD * RATIO / 2) clk_ref = ~clk_ref;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Per-cycle step monitor (R5, R4, R7): each change must be +/-1 in the expected direction.
  always @(negedge clk_loc) begin
    if (!mon_on) begin
      prev_trim = int'(trim);
    end else if (int'(trim) != prev_trim) begin
      chk(int'(trim) - prev_trim == mon_dir, "R5 trim step", int'(trim) - prev_trim, mon_dir);
      prev_trim = int'(trim);
    end
  end

  task automatic wait_loc(input int n);
    repeat (n) @(negedge clk_loc);
  endtask

  task automatic start(input int w, input int e, input int t);
    mon_on  = 1'b0;
    en      = 1'b0;
    rst_n   = 1'b0;
    win_len = WIN_W'(w);
    exp_cnt = CNT_W'(e);
    tol     = CNT_W'(t);
    wait_loc(3);
    rst_n = 1'b1;
    wait_loc(6);
    en = 1'b1;
  endtask

  task automatic run_case(input int w, input int e, input int t);
    int m, exp_trim, exp_lock;
    m = w * RATIO;
    if (m > CMAX) m = CMAX;
    if (m > e + t) begin
      mon_dir = -1; exp_trim = -32; exp_lock = 0;
    end else if (m + t < e) begin
      mon_dir = 1; exp_trim = 31; exp_lock = 0;
    end else begin
      mon_dir = 0; exp_trim = 0; exp_lock = 1;
    end
    start(w, e, t);
    mon_on = 1'b1;
    wait_loc(70 * m + 60);
    mon_on = 1'b0;
    chk(int'(meas_cnt) == m, "R2 meas_cnt", int'(meas_cnt), m);
    if (mon_dir < 0)      chk(int'(trim) == exp_trim, "R4/R6 trim floor", int'(trim), exp_trim);
    else if (mon_dir > 0) chk(int'(trim) == exp_trim, "R5/R6 trim ceiling", int'(trim), exp_trim);
    else                  chk(int'(trim) == exp_trim, "R7 trim held in band", int'(trim), exp_trim);
    chk(int'(locked) == exp_lock, "R7 locked", int'(locked), exp_lock);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    mon_on = 1'b0; mon_dir = 0; prev_trim = 0;
    en = 1'b0; rst_n = 1'b0;
    exp_cnt = '0; tol = '0; win_len = WIN_W'(8);

    // R1: reset state
    wait_loc(3);
    chk(int'(trim) == 0, "R1 trim", int'(trim), 0);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);
    chk(int'(meas_cnt) == 0, "R1 meas_cnt", int'(meas_cnt), 0);
    rst_n = 1'b1;
    wait_loc(3);
    chk(int'(trim) == 0 && int'(meas_cnt) == 0, "R1 after release", int'(trim), 0);

    // R3: first window after enable is only a restart
    start(8, 100, 0);
    wait_loc(60);
    chk(int'(trim) == 0, "R3 first window skipped", int'(trim), 0);
    wait_loc(40);
    chk(int'(trim) == 1, "R3 second window acts", int'(trim), 1);

    // Sweep: window lengths x tolerances x expected offsets around the true count
    for (int wi = 0; wi < 2; wi++) begin
      for (int ti = 0; ti < 2; ti++) begin
        for (int d = -3; d <= 3; d++) begin
          run_case((wi == 0) ? 6 : 8, RATIO * ((wi == 0) ? 6 : 8) + d, 2 * ti);
        end
      end
    end

    // R7 early: locked must not be set before LOCK_N in-band windows
    start(8, 32, 1);
    wait_loc(3 * 32);
    chk(locked == 1'b0, "R7 not yet locked", int'(locked), 0);
    wait_loc(6 * 32);
    chk(locked == 1'b1, "R7 locked after run", int'(locked), 1);

    // R8: disable clears lock and keeps trim
    en = 1'b0;
    wait_loc(5);
    chk(locked == 1'b0, "R8 lock cleared", int'(locked), 0);
    chk(int'(trim) == 0, "R8 trim held", int'(trim), 0);
    // Drift the trim, then disable again while it is non-zero
    exp_cnt = CNT_W'(60);
    en = 1'b1;
    wait_loc(6 * 32);
    begin
      int held;
      held = int'(trim);
      chk(held > 0, "R5 trim rose before disable", held, 1);
      en = 1'b0;
      wait_loc(200);
      chk(int'(trim) == held, "R8 trim held while disabled", int'(trim), held);
      chk(locked == 1'b0, "R8 locked low while disabled", int'(locked), 0);
    end

    // R9: over-long window saturates the local count and reads as fast
    start(300, 1000, 5);
    wait_loc(5 * 1200 + 100);
    chk(int'(meas_cnt) == CMAX, "R9 meas saturated", int'(meas_cnt), CMAX);
    chk(int'(trim) < 0, "R9 treated as fast", int'(trim), -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_loc);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule